// File: doc/BRIEF.md
# Byte-Wide Multi-Cycle Register Machine

This block is a compact processor core. Control and datapath are kept apart. It runs programs of 16-bit instructions held in an on-block instruction store. It operates on four 8-bit general registers and a 256-byte data store. Each instruction takes a fetch cycle and then an execute cycle. The core advances its 13-bit program counter by one after every instruction except HALT.

The core reaches the outside world through one 8-bit output channel and one 8-bit input channel. Each channel uses a valid/ready handshake, and the instruction that uses a channel stalls until the transfer completes. While the core is held in reset, a simple write port (address, word, enable) fills the instruction store. When reset is released, execution starts at address zero. Once HALT executes, the core raises `halted` and does nothing more until the next reset.

Top module: `byte_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core clears its program counter, all four registers and the halted state. After that edge `halted`, `out_valid` and `in_ready` are low, and a register read before any write returns 0.
- R2: Opcode 0 (add) and opcode 1 (subtract) compute dst = dst op src2 modulo 256. Instruction bits are [15:12] opcode, [11:10] dst, [9:8] src2 and [7:0] immediate.
- R3: Opcode 2 (multiply) writes the low 8 bits of dst * src2 into dst.
- R4: Opcode 5 writes the immediate field [7:0] into dst.
- R5: Opcode 4 stores dst into the data store at the address held in src2. Opcode 3 loads the byte at the address held in src2 into dst.
- R6: Opcode 6 raises `out_valid` with `out_data` equal to dst. Both stay unchanged until a clock edge where `out_ready` is high, and exactly one transfer happens per instruction.
- R7: Opcode 7 raises `in_ready` and holds it until a clock edge where `in_valid` is high. At that edge `in_data` is written into dst.
- R8: Opcode 8 raises `halted`, which then stays high. After it, no instruction executes and no output transfer occurs.
- R9: Opcodes 9 to 15 change no register and no memory, and execution continues with the next instruction.
- R10: Instructions run in address order, and the program counter advances by exactly one per completed non-halting instruction.
- R11: A write on the load port while `rst` is high stores `load_data` at `load_addr`. The first instruction fetched after reset is the one at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_we | input | 1 | Instruction-store write enable, honoured only during reset |
| load_addr | input | 13 | Instruction-store write address |
| load_data | input | 16 | Instruction word to store |
| out_data | output | 8 | Output channel value |
| out_valid | output | 1 | Output channel holds a value |
| out_ready | input | 1 | Consumer accepts the output value |
| in_data | input | 8 | Input channel value |
| in_valid | input | 1 | Producer offers an input value |
| in_ready | output | 1 | Core waits for an input value |
| halted | output | 1 | HALT has executed |

## Verification
The assertions assume the consumer and producer obey the handshake. They also assume that `in_data` carries a defined value whenever `in_valid` is high. Beyond that, they make no assumption on how long either side stalls.

The stimulus drives `out_ready` in a stalling pattern for one program and holds it high for the other. It raises `in_valid` only while `in_ready` is seen, and only on alternate cycles, so that input waits occur. The load port is driven only while reset is held. Every program ends in HALT, so no undefined instruction word is ever fetched.

// File: rtl/bc_pkg.sv
package bc_pkg;
  localparam int DATA_W = 8;
  localparam int OPC_W  = 4;
  localparam int RIDX_W = 2;
  localparam int INST_W = OPC_W + 2 * RIDX_W + DATA_W;

  localparam logic [OPC_W-1:0] OPC_ADD  = 4'd0;
  localparam logic [OPC_W-1:0] OPC_SUB  = 4'd1;
  localparam logic [OPC_W-1:0] OPC_MUL  = 4'd2;
  localparam logic [OPC_W-1:0] OPC_LD   = 4'd3;
  localparam logic [OPC_W-1:0] OPC_ST   = 4'd4;
  localparam logic [OPC_W-1:0] OPC_LI   = 4'd5;
  localparam logic [OPC_W-1:0] OPC_OUT  = 4'd6;
  localparam logic [OPC_W-1:0] OPC_IN   = 4'd7;
  localparam logic [OPC_W-1:0] OPC_HALT = 4'd8;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rs;
    logic [DATA_W-1:0] imm;
  } inst_t;

  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_IMM, WB_IN} wb_e;

  function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DATA_W-1:0] wrap_sub(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a - b;
  endfunction

  function automatic logic [DATA_W-1:0] low_mul(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    logic [2*DATA_W-1:0] p;
    p = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
    return p[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] alu_eval(input logic [OPC_W-1:0] opc,
                                                 input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    case (opc)
      OPC_SUB: return wrap_sub(a, b);
      OPC_MUL: return low_mul(a, b);
      default: return wrap_add(a, b);
    endcase
  endfunction
endpackage

// File: rtl/bc_imem.sv
module bc_imem #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [WORD_W-1:0] store [DEPTH];
  logic [IDX_W-1:0]  widx, ridx;

  generate
    if (IDX_W < ADDR_W) begin : g_fold
      logic unused_hi;
      assign unused_hi = ^{waddr[ADDR_W-1:IDX_W], raddr[ADDR_W-1:IDX_W]};
    end
  endgenerate

  assign widx  = waddr[IDX_W-1:0];
  assign ridx  = raddr[IDX_W-1:0];
  assign rdata = store[ridx];

  always_ff @(posedge clk) begin
    if (we) store[widx] <= wdata;
  end
endmodule

// File: rtl/bc_dmem.sv
module bc_dmem #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  assign rdata = cells[addr];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end
endmodule

// File: rtl/bc_regfile.sv
module bc_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [$clog2(NREG)-1:0] ra_addr,
  output logic [DW-1:0]           ra_data,
  input  logic [$clog2(NREG)-1:0] rb_addr,
  output logic [DW-1:0]           rb_data
);
  logic [DW-1:0] regs [NREG];

  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/bc_alu.sv
module bc_alu
  import bc_pkg::*;
(
  input  logic [OPC_W-1:0]  opc,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb y = alu_eval(opc, a, b);
endmodule

// File: rtl/bc_control.sv
module bc_control
  import bc_pkg::*;
#(
  parameter int PC_W = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  inst_t           fetched,
  input  logic            out_ready,
  input  logic            in_valid,
  output logic [PC_W-1:0] pc,
  output inst_t           inst,
  output logic            rf_we,
  output wb_e             wb_sel,
  output logic            dm_we,
  output logic            out_valid,
  output logic            in_ready,
  output logic            halted,
  output logic            retire
);
  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_HALT} state_e;

  state_e state_q;
  logic   halt_evt;
  logic   done;

  always_comb begin
    rf_we     = 1'b0;
    wb_sel    = WB_ALU;
    dm_we     = 1'b0;
    out_valid = 1'b0;
    in_ready  = 1'b0;
    halt_evt  = 1'b0;
    done      = 1'b0;
    if (state_q == S_EXEC) begin
      done = 1'b1;
      case (inst.opc)
        OPC_ADD, OPC_SUB, OPC_MUL: rf_we = 1'b1;
        OPC_LD: begin
          rf_we  = 1'b1;
          wb_sel = WB_MEM;
        end
        OPC_ST: dm_we = 1'b1;
        OPC_LI: begin
          rf_we  = 1'b1;
          wb_sel = WB_IMM;
        end
        OPC_OUT: begin
          out_valid = 1'b1;
          done      = out_ready;
        end
        OPC_IN: begin
          in_ready = 1'b1;
          wb_sel   = WB_IN;
          rf_we    = in_valid;
          done     = in_valid;
        end
        OPC_HALT: begin
          halt_evt = 1'b1;
          done     = 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign retire = done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_FETCH;
      pc      <= '0;
      inst    <= '0;
      halted  <= 1'b0;
    end else begin
      case (state_q)
        S_FETCH: begin
          inst    <= fetched;
          state_q <= S_EXEC;
        end
        S_EXEC: begin
          if (halt_evt) begin
            halted  <= 1'b1;
            state_q <= S_HALT;
          end else if (done) begin
            pc      <= pc + 1'b1;
            state_q <= S_FETCH;
          end
        end
        default: state_q <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/byte_core.sv
module byte_core
  import bc_pkg::*;
#(
  parameter int PC_W       = 13,
  parameter int IMEM_DEPTH = 1024,
  parameter int DMEM_AW    = 8,
  parameter int NREG       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_we,
  input  logic [PC_W-1:0]   load_addr,
  input  logic [INST_W-1:0] load_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              halted
);
  logic [PC_W-1:0]   pc_w;
  logic [INST_W-1:0] fetched_w;
  inst_t             inst_w;
  logic              rf_we_w, dm_we_w, retire_w;
  wb_e               wb_sel_w;
  logic [DATA_W-1:0] dst_val, src_val, alu_y, mem_rd, wb_data;

  bc_imem #(.WORD_W(INST_W), .ADDR_W(PC_W), .DEPTH(IMEM_DEPTH)) u_imem (
    .clk(clk), .we(load_we & rst), .waddr(load_addr), .wdata(load_data),
    .raddr(pc_w), .rdata(fetched_w)
  );

  bc_control #(.PC_W(PC_W)) u_ctrl (
    .clk(clk), .rst(rst), .fetched(inst_t'(fetched_w)),
    .out_ready(out_ready), .in_valid(in_valid),
    .pc(pc_w), .inst(inst_w), .rf_we(rf_we_w), .wb_sel(wb_sel_w),
    .dm_we(dm_we_w), .out_valid(out_valid), .in_ready(in_ready),
    .halted(halted), .retire(retire_w)
  );

  bc_regfile #(.DW(DATA_W), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we_w), .waddr(inst_w.rd), .wdata(wb_data),
    .ra_addr(inst_w.rd), .ra_data(dst_val),
    .rb_addr(inst_w.rs), .rb_data(src_val)
  );

  bc_alu u_alu (.opc(inst_w.opc), .a(dst_val), .b(src_val), .y(alu_y));

  bc_dmem #(.DW(DATA_W), .AW(DMEM_AW)) u_dmem (
    .clk(clk), .we(dm_we_w), .addr(src_val[DMEM_AW-1:0]), .wdata(dst_val),
    .rdata(mem_rd)
  );

  always_comb begin
    case (wb_sel_w)
      WB_MEM:  wb_data = mem_rd;
      WB_IMM:  wb_data = inst_w.imm;
      WB_IN:   wb_data = in_data;
      default: wb_data = alu_y;
    endcase
  end

  assign out_data = dst_val;
endmodule

// File: rtl/byte_core_chk.sv
module byte_core_chk #(
  parameter int PC_W = 13
) (
  input logic            clk,
  input logic            rst,
  input logic            halted,
  input logic            out_valid,
  input logic            out_ready,
  input logic [7:0]      out_data,
  input logic            in_valid,
  input logic            in_ready,
  input logic            retire,
  input logic [PC_W-1:0] pc
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!halted && !out_valid && !in_ready));

  p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_in_wait_r7: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> in_ready);

  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!out_valid && !in_ready && !retire));

  p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
    retire |=> (pc == $past(pc) + 1'b1));

  p_pc_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !retire |=> $stable(pc));
endmodule

bind byte_core byte_core_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .halted(halted), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .in_valid(in_valid),
  .in_ready(in_ready), .retire(retire_w), .pc(pc_w)
);

// File: tb/byte_core_tb.sv
module byte_core_tb;
  localparam int PC_W = 13;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst = 1'b1;
  logic            load_we = 1'b0;
  logic [PC_W-1:0] load_addr = '0;
  logic [15:0]     load_data = '0;
  logic [7:0]      out_data;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [7:0]      in_data = '0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic            halted;

  byte_core u_dut (
    .clk(clk), .rst(rst), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .halted(halted)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;

  logic [15:0] prog [$];
  logic [7:0]  exp_q [$];
  string       tag_q [$];
  logic [7:0]  in_q [$];

  function automatic logic [15:0] enc(int op, int d, int s, int imm);
    return {op[3:0], d[1:0], s[1:0], imm[7:0]};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver side: an instruction, plus an optional expected output item
  task automatic put(logic [15:0] w);
    prog.push_back(w);
  endtask

  task automatic put_out(int d, logic [7:0] val, string req);
    prog.push_back(enc(6, d, 0, 0));
    exp_q.push_back(val);
    tag_q.push_back(req);
  endtask

  // monitor and channel partner, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    out_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected output", out_data, 0);
      end else begin
        string t;
        logic [7:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_data == e, t, out_data, e);
      end
    end
    if (in_ready && in_q.size() > 0 && (cyc % 2 == 0)) begin
      in_valid = 1'b1;
      in_data  = in_q.pop_front();
    end else begin
      in_valid = 1'b0;
    end
  end

  task automatic load_and_run();
    rst = 1'b1;
    @(posedge clk); #2;
    for (int i = 0; i < prog.size(); i++) begin
      load_we   = 1'b1;
      load_addr = PC_W'(i);
      load_data = prog[i];
      @(posedge clk); #2;
    end
    load_we = 1'b0;
    // R1: state after reset edges
    check(!halted && !out_valid && !in_ready, "R1 reset outputs",
          {halted, out_valid, in_ready}, 0);
    rst = 1'b0;
  endtask

  task automatic wait_halt(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk); #2;
      if (halted) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic after_halt(string tagname);
    int seen;
    seen = 0;
    check(exp_q.size() == 0, "R10 outputs pending at halt", exp_q.size(), 0);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #2;
      if (out_valid || !halted) seen++;
    end
    check(seen == 0, tagname, seen, 0);
  endtask

  initial begin
    bit ok;
    // program A
    put(enc(5, 0, 0, 8'hC8));
    put(enc(5, 1, 0, 8'h64));
    put(enc(0, 0, 1, 0));
    put_out(0, 8'h2C, "R2 add wrap");
    put(enc(5, 2, 0, 8'h05));
    put(enc(1, 2, 1, 0));
    put_out(2, 8'hA1, "R2 sub wrap");
    put(enc(5, 3, 0, 8'd27));
    put(enc(5, 1, 0, 8'd19));
    put(enc(2, 3, 1, 0));
    put_out(3, 8'h01, "R3 mult low byte");
    put(enc(5, 0, 0, 8'hA5));
    put_out(0, 8'hA5, "R4 load immediate");
    put(enc(5, 1, 0, 8'h30));
    put(enc(5, 0, 0, 8'h5C));
    put(enc(4, 0, 1, 0));
    put(enc(5, 2, 0, 8'hFF));
    put(enc(5, 3, 0, 8'h77));
    put(enc(4, 3, 2, 0));
    put(enc(5, 0, 0, 0));
    put(enc(5, 3, 0, 0));
    put(enc(3, 0, 1, 0));
    put_out(0, 8'h5C, "R5 load from 0x30");
    put(enc(3, 3, 2, 0));
    put_out(3, 8'h77, "R5 load from 0xFF");
    put(enc(9, 0, 1, 8'hFF));
    put(enc(15, 0, 0, 8'h11));
    put(enc(12, 0, 0, 8'h00));
    put_out(0, 8'h5C, "R9 unused opcodes no effect");
    put(enc(7, 2, 0, 0));
    in_q.push_back(8'h3C);
    put_out(2, 8'h3C, "R7 input value");
    put(enc(7, 1, 0, 0));
    in_q.push_back(8'hE1);
    put(enc(0, 1, 2, 0));
    put_out(1, 8'h1D, "R7 input then add");
    put(enc(8, 0, 0, 0));
    put(enc(6, 0, 0, 0));
    put(enc(5, 0, 0, 8'h99));

    stall_mode = 1'b1;
    load_and_run();
    wait_halt(ok);
    check(ok, "R8 halted raised (watchdog)", ok, 1);
    if (ok) begin
      after_halt("R8 quiet after halt");
      check(in_q.size() == 0, "R7 inputs consumed", in_q.size(), 0);
    end

    // program B: fresh reset, new image
    prog.delete();
    exp_q.delete();
    tag_q.delete();
    in_q.delete();
    put_out(1, 8'h00, "R1 registers cleared");
    put(enc(5, 0, 0, 8'h12));
    put_out(0, 8'h12, "R11 reloaded image");
    put(enc(8, 0, 0, 0));
    stall_mode = 1'b0;
    load_and_run();
    wait_halt(ok);
    check(ok, "R8 halted raised run 2 (watchdog)", ok, 1);
    if (ok) after_halt("R8 quiet after second halt");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule